// File: doc/BRIEF.md
# SPI Memory Slave Serial Front-End with Hold

This block is the serial edge of an SPI memory slave. It watches chip select, the serial clock, the hold line and the data input through synchronizers clocked by a faster system clock. Incoming command, address and data bits are gathered into bytes, most significant bit first. Each finished byte is handed over with a one-cycle strobe and its position in the current frame. Response bytes are taken from a parallel input and shifted out on a serial output that has a separate output-enable, so the pad can be left floating.

Clock modes 0 and 3 are both accepted, with no setting to choose between them. Data in is taken on the rising clock edge and data out moves after the falling edge. A pause line freezes the bit and byte position without clearing them. Pause entry and exit only take effect while the serial clock is low. Raising chip select ends the frame, clears all position state and reports standby, plus an abort indication if a byte was cut short or the block was paused. The serial clock must run at no more than a quarter of the system clock.

Top module: `spi_hold_slave`

## Requirements
- R1: With the serial clock idling low (mode 0) and with it idling high (mode 3), bytes on `si` are received correctly, sampled on rising `sck`, bit 7 first.
- R2: After every eighth counted rising edge, `rx_valid` pulses for exactly one system clock, with the byte on `rx_byte` and its 0-based position in the frame on `rx_index`.
- R3: `so` shows bit 7 of `tx_byte` from the start of the frame. It advances one bit after each falling `sck` that follows a counted rising edge. At the falling edge after the eighth rise it shows bit 7 of a freshly sampled `tx_byte`. Each sampling of `tx_byte` is marked by a one-cycle `tx_load`.
- R4: `so_oe` is 0 whenever `cs_n` is high or the block is paused, and 1 otherwise.
- R5: A pause starts while `cs_n` is low and `hold_n` is low at a moment when `sck` is low. If `hold_n` falls while `sck` is high, the pause starts only at the next low `sck`.
- R6: A pause ends when `hold_n` is high and `sck` is low. If `hold_n` rises while `sck` is high, the pause continues until `sck` next goes low.
- R7: While paused, `sck` and `si` activity is ignored and the bit and byte position are kept, so the byte completed after the pause equals the bits sent outside it.
- R8: A rising `cs_n` gives a one-cycle `standby` pulse. It also gives a one-cycle `abort` pulse if a byte was partly received or the block was paused. It clears the pause, the bit count and the byte position, so the next frame starts at index 0.
- R9: After reset, `so_oe`, `rx_valid`, `tx_load`, `standby` and `abort` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the bus master |
| cs_n | input | 1 | Active-low chip select |
| hold_n | input | 1 | Active-low pause request |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; 0 means high impedance |
| tx_byte | input | DW | Next byte to send, sampled when `tx_load` pulses |
| tx_load | output | 1 | One-cycle pulse: `tx_byte` was taken |
| rx_byte | output | DW | Last complete received byte |
| rx_valid | output | 1 | One-cycle pulse: `rx_byte` is new |
| rx_index | output | IDXW | Position of `rx_byte` in the current frame |
| standby | output | 1 | One-cycle pulse on deselect |
| abort | output | 1 | One-cycle pulse on deselect during a partial byte or a pause |

## Verification
Multi-byte frames are sent in mode 0 and mode 3. These show that the leading falling edge of mode 3 does not shift the output, and that both idle levels give the same bytes and indexes. Pauses are tried in two ways. In one, the pause starts and ends with the clock low and extra clock pulses are sent during it; this shows the pause freezes the position rather than resetting it. In the other, the hold line changes while the clock is high; this shows entry and exit wait for the next low clock. Deselect is tried mid-byte and during a pause with no bits sent, which tells the abort cause apart from plain standby, and a fresh frame after each confirms the index and output restart.

// File: rtl/spi_hold_slave.sv
module spi_hold_slave #(
  parameter int DW   = 8,
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sck,
  input  logic            cs_n,
  input  logic            hold_n,
  input  logic            si,
  output logic            so,
  output logic            so_oe,
  input  logic [DW-1:0]   tx_byte,
  output logic            tx_load,
  output logic [DW-1:0]   rx_byte,
  output logic            rx_valid,
  output logic [IDXW-1:0] rx_index,
  output logic            standby,
  output logic            abort
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [1:0] sck_m, cs_m, hold_m, si_m;
  logic       sck_q, cs_q;
  logic       held, seen;
  logic [CW-1:0]   bit_cnt;
  logic [IDXW-1:0] idx;
  logic [DW-2:0]   rx_sh;
  logic [DW-1:0]   tx_sh;

  wire sck_s  = sck_m[1];
  wire cs_s   = cs_m[1];
  wire hold_s = hold_m[1];
  wire si_s   = si_m[1];

  wire sck_rise = sck_s & ~sck_q;
  wire sck_fall = ~sck_s & sck_q;
  wire cs_start = cs_q & ~cs_s;
  wire cs_end   = ~cs_q & cs_s;
  wire active   = ~cs_s & ~held;

  assign so    = tx_sh[DW-1];
  assign so_oe = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_m  <= 2'b00;
      cs_m   <= 2'b11;
      hold_m <= 2'b11;
      si_m   <= 2'b00;
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sck_m  <= {sck_m[0], sck};
      cs_m   <= {cs_m[0], cs_n};
      hold_m <= {hold_m[0], hold_n};
      si_m   <= {si_m[0], si};
      sck_q  <= sck_s;
      cs_q   <= cs_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      held <= 1'b0;
    else if (cs_s)
      held <= 1'b0;
    else if (!held && !hold_s && !sck_s)
      held <= 1'b1;
    else if (held && hold_s && !sck_s)
      held <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      idx      <= '0;
      seen     <= 1'b0;
      rx_sh    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      rx_index <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (cs_s) begin
        bit_cnt <= '0;
        idx     <= '0;
        seen    <= 1'b0;
      end else if (active && sck_rise) begin
        rx_sh <= {rx_sh[DW-3:0], si_s};
        seen  <= 1'b1;
        if (bit_cnt == LAST) begin
          bit_cnt  <= '0;
          rx_byte  <= {rx_sh, si_s};
          rx_valid <= 1'b1;
          rx_index <= idx;
          idx      <= idx + 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      tx_load <= 1'b0;
    end else begin
      tx_load <= 1'b0;
      if (cs_start) begin
        tx_sh   <= tx_byte;
        tx_load <= 1'b1;
      end else if (active && sck_fall && seen) begin
        if (bit_cnt == '0) begin
          tx_sh   <= tx_byte;
          tx_load <= 1'b1;
        end else begin
          tx_sh <= {tx_sh[DW-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      standby <= 1'b0;
      abort   <= 1'b0;
    end else begin
      standby <= cs_end;
      abort   <= cs_end & ((bit_cnt != '0) | held);
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R2
  AST_VALID_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> bit_cnt == '0); // R2
  AST_HOLD_FREEZES_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !cs_s) |=> ($stable(bit_cnt) && $stable(idx))); // R7
  AST_HOLD_ENTRY_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> !$past(sck_s)); // R5
  AST_HOLD_EXIT_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(held) && !$past(cs_s)) |-> !$past(sck_s)); // R6
  AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (bit_cnt == '0 && idx == '0 && !held)); // R8
endmodule

// File: tb/spi_hold_slave_test.sv
module spi_hold_slave_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0;
  logic so, so_oe, tx_load, rx_valid, standby, abort;
  logic [7:0] tx_byte = 8'hC3;
  logic [7:0] rx_byte;
  logic [3:0] rx_index;

  int n_chk = 0, n_fail = 0;
  int sb_cnt = 0, ab_cnt = 0;
  bit done = 0;
  logic [11:0] exp_q[$];
  logic [7:0]  txsb[$];
  logic [3:0]  idx_exp = '0;
  localparam int HALF = 50;

  always #5 clk = ~clk;

  spi_hold_slave uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n), .si(si),
    .so(so), .so_oe(so_oe), .tx_byte(tx_byte), .tx_load(tx_load),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_index(rx_index),
    .standby(standby), .abort(abort));

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
    end
  endtask

  task automatic finish_test();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (standby) sb_cnt++;
    if (abort) ab_cnt++;
    if (tx_load) begin
      txsb.push_back(tx_byte);
      tx_byte = tx_byte * 8'd5 + 8'h3D;
    end
    if (rx_valid) begin
      if (exp_q.size() == 0)
        chk(0, "R2 unexpected rx_valid", int'({rx_index, rx_byte}), 0);
      else begin
        logic [11:0] e;
        e = exp_q.pop_front();
        chk({rx_index, rx_byte} == e, "R1 R2 received index/byte",
            int'({rx_index, rx_byte}), int'(e));
      end
    end
  end

  task automatic frame_start(input bit m3);
    sck = m3;
    #100 cs_n = 1'b0;
    #100;
    chk(so_oe == 1'b1, "R4 so_oe on select", so_oe, 1);
  endtask

  task automatic frame_end(input int exp_ab);
    int sb0, ab0;
    sb0 = sb_cnt; ab0 = ab_cnt;
    if (sck == 1'b1 && exp_ab < 0) sck = 1'b1;
    #100 cs_n = 1'b1;
    #200;
    chk(sb_cnt - sb0 == 1, "R8 standby pulse count", sb_cnt - sb0, 1);
    chk(ab_cnt - ab0 == exp_ab, "R8 abort pulse count", ab_cnt - ab0, exp_ab);
    chk(so_oe == 1'b0, "R4 so_oe after deselect", so_oe, 0);
    txsb.delete();
    idx_exp = '0;
  endtask

  task automatic xfer(input logic [7:0] mosi, input int hmode, input int hbit);
    logic [7:0] miso, e;
    exp_q.push_back({idx_exp, mosi});
    idx_exp++;
    for (int b = 7; b >= 0; b--) begin
      sck = 1'b0; si = mosi[b];
      if (hmode == 1 && b == hbit) begin
        #20 hold_n = 1'b0;
        #100 chk(so_oe == 1'b0, "R5 hold entry with sck low", so_oe, 0);
        repeat (2) begin
          sck = 1'b1; si = ~si; #50; sck = 1'b0; #50;
        end
        chk(so_oe == 1'b0, "R7 still held while sck toggles", so_oe, 0);
        hold_n = 1'b1;
        #100 chk(so_oe == 1'b1, "R6 hold exit with sck low", so_oe, 1);
        si = mosi[b];
      end
      #HALF;
      miso[b] = so;
      sck = 1'b1;
      #HALF;
      if (hmode == 2 && b == hbit) begin
        hold_n = 1'b0;
        #100 chk(so_oe == 1'b1, "R5 entry deferred while sck high", so_oe, 1);
        sck = 1'b0;
        #100 chk(so_oe == 1'b0, "R5 entry at next sck low", so_oe, 0);
        sck = 1'b1; si = ~si;
        #50 hold_n = 1'b1;
        #100 chk(so_oe == 1'b0, "R6 exit deferred while sck high", so_oe, 0);
      end
    end
    if (hmode == 2 || hmode == 1)
      chk(so_oe == 1'b1, "R6 active after hold", so_oe, 1);
    if (txsb.size() == 0)
      chk(0, "R3 no tx_load for byte", 0, 1);
    else begin
      e = txsb.pop_front();
      chk(miso == e, "R3 serial output byte", miso, e);
    end
  endtask

  task automatic partial(input int nbits);
    for (int b = 0; b < nbits; b++) begin
      sck = 1'b0; si = b[0];
      #HALF; sck = 1'b1; #HALF;
    end
  endtask

  initial begin
    #2000000;
    chk(0, "watchdog expired", 0, 1);
    finish_test();
  end

  initial begin
    #53;
    chk(so_oe == 1'b0, "R9 so_oe in reset", so_oe, 0);
    chk(rx_valid == 1'b0 && tx_load == 1'b0, "R9 strobes in reset", {rx_valid, tx_load}, 0);
    chk(standby == 1'b0 && abort == 1'b0, "R9 standby/abort in reset", {standby, abort}, 0);
    rst_n = 1'b1;
    #100;

    frame_start(1'b0);
    xfer(8'h03, 0, 0);
    xfer(8'h5A, 0, 0);
    xfer(8'hF0, 0, 0);
    sck = 1'b0;
    frame_end(0);

    frame_start(1'b1);
    xfer(8'h9C, 0, 0);
    xfer(8'h21, 1, 5);
    xfer(8'hE7, 2, 4);
    frame_end(0);

    frame_start(1'b0);
    xfer(8'hAA, 2, 2);
    xfer(8'h0F, 1, 7);
    sck = 1'b0;
    frame_end(0);

    frame_start(1'b0);
    partial(3);
    sck = 1'b0;
    frame_end(1);

    frame_start(1'b0);
    hold_n = 1'b0;
    #100 chk(so_oe == 1'b0, "R4 so_oe low while held", so_oe, 0);
    cs_n = 1'b1;
    #100 hold_n = 1'b1;
    #200;
    chk(sb_cnt > 0 && ab_cnt == 2, "R8 abort on deselect during hold", ab_cnt, 2);
    txsb.delete();
    idx_exp = '0;

    frame_start(1'b1);
    xfer(8'h81, 0, 0);
    xfer(8'h7E, 0, 0);
    frame_end(0);

    #200;
    chk(exp_q.size() == 0, "R2 all expected bytes received", exp_q.size(), 0);
    finish_test();
  end
endmodule